// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Event Capture

This block is a general-purpose I/O port of up to 32 pins, accessed over a small word-addressed register bus. For each pin, software can drive a value, choose the direction, enable an interrupt, and check whether a pin event has been captured. The pad drivers are controlled through a per-pin output-enable vector, which a tri-state buffer outside the block uses. Every pin input passes through a two-stage synchronizer before the block examines it.

The interrupt trigger mode is fixed when the block is built. It is one of rising edge, falling edge, either edge, or high level. In the three edge modes, each detected event sets a sticky capture bit. Software clears a capture bit by writing a 1 to it. The interrupt output is high while any captured bit is also enabled. In level mode no events are captured, and the interrupt output follows the enabled, synchronized pin levels.

Top module: `mmio_gpio`

## Requirements
- R1: While reset is asserted and just after it is released, the following are all zero: `pinOe`, `pinOut`, `irqOut`, the enable register and the capture register.
- R2: The register selected by word index `busAddr` is: 0 output/data, 1 direction, 2 interrupt enable, 3 capture. A read appears on `busRdData` in the same cycle as the address. A write with `busWrEn` high takes effect at the next clock edge.
- R3: Direction bit n set to 1 makes pin n an output, and 0 makes it an input. `pinOe` equals the direction register and `pinOut` equals the output register. The output register changes only when index 0 is written.
- R4: A read of index 0 returns the output register bit for output pins and the synchronized input level for input pins.
- R5: Inputs pass through two flops. A pin change that is stable before clock edge k is readable after edge k+1. Its capture bit is set after edge k+2.
- R6: An event is a change of the synchronized level from one cycle to the next. Rising mode captures 0-to-1 changes only. Falling mode captures 1-to-0 changes only. Both-edge mode captures either.
- R7: Writing 1 to a capture bit clears it. Writing 0 leaves it unchanged.
- R8: If a new event on a pin arrives in the same cycle that its capture bit is cleared, the bit remains set.
- R9: In edge modes, `irqOut` is high exactly when the bitwise AND of the capture register and the enable register is nonzero.
- R10: In level mode, `irqOut` is high exactly when the bitwise AND of the synchronized pin levels and the enable register is nonzero. The capture register reads zero in this mode.
- R11: Register bits at or above `PIN_COUNT` read as zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Register word index |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for the selected register |
| pinIn | input | PIN_COUNT | Pin levels from the pads |
| pinOut | output | PIN_COUNT | Values driven on output pins |
| pinOe | output | PIN_COUNT | Per-pin output enable |
| irqOut | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a capture-bit clear that lands on the same clock edge as a new event on that pin. The bench first sets the capture bit and lets the pin return low. It then raises the pin and asserts the clear write exactly two negative edges later, so the write strobe spans the edge on which the synchronizer reports the change. The same stimulus also goes to a falling-edge instance, which sees no event at that moment. That instance must lose the bit, which shows that the clear itself works and that only the coinciding event keeps the bit set.

// File: rtl/mmio_gpio_pkg.sv
package mmio_gpio_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    TRIG_RISE  = 2'd0,
    TRIG_FALL  = 2'd1,
    TRIG_BOTH  = 2'd2,
    TRIG_LEVEL = 2'd3
  } trigMode_e;

  // Word index decoding: behaviour depends on this order.
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_CAP  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrData;
    logic    wrDir;
    logic    wrMask;
    logic    wrCap;
    regSel_e rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/mmio_gpio_ctrl.sv
module mmio_gpio_ctrl
  import mmio_gpio_pkg::*;
(
  input  logic [1:0]  busAddr,
  input  logic        busWrEn,
  output ctrlStrobe_t strobe
);
  regSel_e sel;

  always_comb begin
    sel           = regSel_e'(busAddr);
    strobe.rdSel  = sel;
    strobe.wrData = busWrEn && (sel == SEL_DATA);
    strobe.wrDir  = busWrEn && (sel == SEL_DIR);
    strobe.wrMask = busWrEn && (sel == SEL_MASK);
    strobe.wrCap  = busWrEn && (sel == SEL_CAP);
  end
endmodule

// File: rtl/mmio_gpio_dp.sv
module mmio_gpio_dp
  import mmio_gpio_pkg::*;
#(
  parameter int        PIN_COUNT = 32,
  parameter trigMode_e TRIG_MODE = TRIG_RISE
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [BUS_W-1:0]     busWrData,
  output logic [BUS_W-1:0]     busRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic                 irqOut
);
  logic [PIN_COUNT-1:0] wrBits;
  logic [PIN_COUNT-1:0] syncStage1, syncLevel, syncPrev;
  logic [PIN_COUNT-1:0] outReg, dirReg, maskReg, capReg;
  logic [PIN_COUNT-1:0] eventHit, pinView;

  assign wrBits = busWrData[PIN_COUNT-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncStage1 <= '0;
      syncLevel  <= '0;
      syncPrev   <= '0;
    end else begin
      syncStage1 <= pinIn;
      syncLevel  <= syncStage1;
      syncPrev   <= syncLevel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg  <= '0;
      dirReg  <= '0;
      maskReg <= '0;
    end else begin
      if (strobe.wrData) outReg  <= wrBits;
      if (strobe.wrDir)  dirReg  <= wrBits;
      if (strobe.wrMask) maskReg <= wrBits;
    end
  end

  generate
    case (TRIG_MODE)
      TRIG_RISE: begin : g_rise
        assign eventHit = syncLevel & ~syncPrev;
      end
      TRIG_FALL: begin : g_fall
        assign eventHit = ~syncLevel & syncPrev;
      end
      TRIG_BOTH: begin : g_both
        assign eventHit = syncLevel ^ syncPrev;
      end
      default: begin : g_level
        assign eventHit = '0;
      end
    endcase

    if (TRIG_MODE == TRIG_LEVEL) begin : g_noCap
      assign capReg = '0;
      assign irqOut = |(syncLevel & maskReg);
    end else begin : g_cap
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) capReg <= '0;
        else       capReg <= (capReg & ~(strobe.wrCap ? wrBits : '0)) | eventHit;
      end
      assign irqOut = |(capReg & maskReg);
    end
  endgenerate

  assign pinView = (dirReg & outReg) | (~dirReg & syncLevel);
  assign pinOut  = outReg;
  assign pinOe   = dirReg;

  always_comb begin
    unique case (strobe.rdSel)
      SEL_DATA: busRdData = BUS_W'(pinView);
      SEL_DIR:  busRdData = BUS_W'(dirReg);
      SEL_MASK: busRdData = BUS_W'(maskReg);
      default:  busRdData = BUS_W'(capReg);
    endcase
  end
endmodule

// File: rtl/mmio_gpio.sv
module mmio_gpio
  import mmio_gpio_pkg::*;
#(
  parameter int        PIN_COUNT = 32,
  parameter trigMode_e TRIG_MODE = TRIG_RISE
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           busAddr,
  input  logic                 busWrEn,
  input  logic [31:0]          busWrData,
  output logic [31:0]          busRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic                 irqOut
);
  ctrlStrobe_t strobe;

  mmio_gpio_ctrl u_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strobe (strobe)
  );

  mmio_gpio_dp #(
    .PIN_COUNT(PIN_COUNT),
    .TRIG_MODE(TRIG_MODE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .irqOut   (irqOut)
  );
endmodule

// File: rtl/mmio_gpio_chk.sv
module mmio_gpio_chk
  import mmio_gpio_pkg::*;
#(
  parameter int        PIN_COUNT = 32,
  parameter trigMode_e TRIG_MODE = TRIG_RISE
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [1:0]           busAddr,
  input logic                 busWrEn,
  input logic [31:0]          busWrData,
  input logic [31:0]          busRdData,
  input logic [PIN_COUNT-1:0] pinOut,
  input logic [PIN_COUNT-1:0] pinOe,
  input logic                 irqOut
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!irqOut && pinOe == '0 && pinOut == '0));

  assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd1) |=> (pinOe == $past(busWrData[PIN_COUNT-1:0])));

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == 2'd0) |=> $stable(pinOut));

  assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((TRIG_MODE != TRIG_LEVEL) && $fell(irqOut)) |-> $past(busWrEn && busAddr[1]));

  assert_level_nocap_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((TRIG_MODE == TRIG_LEVEL) && busAddr == 2'd3) |-> (busRdData == '0));

  assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busRdData >> PIN_COUNT) == '0);
endmodule

bind mmio_gpio mmio_gpio_chk #(
  .PIN_COUNT(PIN_COUNT),
  .TRIG_MODE(TRIG_MODE)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWrData(busWrData),
  .busRdData(busRdData),
  .pinOut   (pinOut),
  .pinOe    (pinOe),
  .irqOut   (irqOut)
);

// File: tb/tb_mmio_gpio.sv
`timescale 1ns/1ps
module tb_mmio_gpio;
  import mmio_gpio_pkg::*;
  localparam int PINS = 12;

  typedef struct packed {
    logic [1:0]  wAddr;
    logic [31:0] wData;
    logic [1:0]  rAddr;
    logic [31:0] expRd;
  } vec_t;

  // Register access table (R2, R4, R11): write, then read back.
  localparam vec_t VEC [6] = '{
    '{2'd1, 32'hFFFF_F0F0, 2'd1, 32'h0000_00F0},
    '{2'd0, 32'hFFFF_FABC, 2'd0, 32'h0000_00B0},
    '{2'd2, 32'hFFFF_0003, 2'd2, 32'h0000_0003},
    '{2'd1, 32'h0000_0FFF, 2'd0, 32'h0000_0ABC},
    '{2'd1, 32'h0000_0000, 2'd0, 32'h0000_0000},
    '{2'd0, 32'h0000_000A, 2'd1, 32'h0000_0000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [PINS-1:0] pinIn = '0;
  logic [31:0] rdRise, rdFall, rdLvl;
  logic [PINS-1:0] outRise, outFall, outLvl, oeRise, oeFall, oeLvl;
  logic irqRise, irqFall, irqLvl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mmio_gpio #(.PIN_COUNT(PINS), .TRIG_MODE(TRIG_RISE)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(rdRise), .pinIn(pinIn),
    .pinOut(outRise), .pinOe(oeRise), .irqOut(irqRise));

  mmio_gpio #(.PIN_COUNT(PINS), .TRIG_MODE(TRIG_FALL)) dutFall (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(rdFall), .pinIn(pinIn),
    .pinOut(outFall), .pinOe(oeFall), .irqOut(irqFall));

  mmio_gpio #(.PIN_COUNT(PINS), .TRIG_MODE(TRIG_LEVEL)) dutLvl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(rdLvl), .pinIn(pinIn),
    .pinOut(outLvl), .pinOe(oeLvl), .irqOut(irqLvl));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a);
    busAddr = a;
    #1;
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    waitNeg(3);
    // R1: state while in reset
    check("R1 pinOe in reset", 32'(oeRise), 32'h0);
    check("R1 irq in reset", {31'h0, irqRise | irqFall | irqLvl}, 32'h0);
    rstN = 1'b1;
    waitNeg(1);
    check("R1 pinOut after reset", 32'(outRise), 32'h0);
    busRead(2'd2); check("R1 mask after reset", rdRise, 32'h0);
    busRead(2'd3); check("R1 capture after reset", rdRise, 32'h0);

    // R2 R4 R11: table walk
    for (int i = 0; i < 6; i++) begin
      busWrite(VEC[i].wAddr, VEC[i].wData);
      busRead(VEC[i].rAddr);
      check($sformatf("R2 R4 R11 vector %0d", i), rdRise, VEC[i].expRd);
    end

    // R3: outputs driven from direction and data registers
    busWrite(2'd1, 32'h0000_000F);
    check("R3 pinOe", 32'(oeRise), 32'h0000_000F);
    check("R3 pinOut", 32'(outRise), 32'h0000_000A);
    busRead(2'd0); check("R4 mixed readback", rdRise, 32'h0000_000A);
    busWrite(2'd1, 32'h0);

    // R5 R6 R9 R10: rising pattern 0x5A5, enable mask = 0x3
    @(negedge clk); pinIn = 12'h5A5;
    busRead(2'd0); check("R5 no change before sync", rdRise, 32'h0);
    waitNeg(1); busRead(2'd0); check("R5 still synchronizing", rdRise, 32'h0);
    waitNeg(1); busRead(2'd0); check("R5 synced level", rdRise, 32'h5A5);
    busRead(2'd3); check("R5 capture not yet set", rdRise, 32'h0);
    waitNeg(1);
    busRead(2'd3); check("R6 rising capture", rdRise, 32'h5A5);
    check("R6 falling ignores rise", rdFall, 32'h0);
    check("R10 level capture zero", rdLvl, 32'h0);
    check("R9 irq rising", {31'h0, irqRise}, 32'h1);
    check("R9 irq falling quiet", {31'h0, irqFall}, 32'h0);
    check("R10 level irq high", {31'h0, irqLvl}, 32'h1);

    // R7: write-one-to-clear
    busWrite(2'd3, 32'h0);
    busRead(2'd3); check("R7 zero write keeps bits", rdRise, 32'h5A5);
    busWrite(2'd3, 32'h1);
    busRead(2'd3); check("R7 clear bit0", rdRise, 32'h5A4);
    check("R9 irq drops after clear", {31'h0, irqRise}, 32'h0);

    // R6 R10: falling pattern
    @(negedge clk); pinIn = 12'h000;
    waitNeg(3);
    busRead(2'd3);
    check("R6 falling capture", rdFall, 32'h5A5);
    check("R6 rising ignores fall", rdRise, 32'h5A4);
    check("R9 irq falling instance", {31'h0, irqFall}, 32'h1);
    check("R10 level irq low", {31'h0, irqLvl}, 32'h0);

    // R8: event on pin 2 lands on the same edge as its clear
    @(negedge clk); pinIn = 12'h004;
    @(negedge clk);
    @(negedge clk); busAddr = 2'd3; busWrData = 32'h4; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
    busRead(2'd3);
    check("R8 event beats clear", rdRise, 32'h5A4);
    check("R7 clear without event", rdFall, 32'h5A1);
    busWrite(2'd3, 32'h4);
    busRead(2'd3); check("R7 later clear works", rdRise, 32'h5A0);

    // R9: enable mask gates the interrupt
    busWrite(2'd2, 32'h0);
    check("R9 masked off", {31'h0, irqRise}, 32'h0);
    busWrite(2'd2, 32'h20);
    check("R9 enabled bit5", {31'h0, irqRise}, 32'h1);
    check("R10 level irq other pin", {31'h0, irqLvl}, 32'h0);

    // R11: writes above the pin count are ignored
    busWrite(2'd2, 32'hFFFF_F000);
    busRead(2'd2); check("R11 upper mask ignored", rdRise, 32'h0);
    check("R11 irq off", {31'h0, irqRise}, 32'h0);

    // R1: reset again from a busy state
    busWrite(2'd1, 32'hFFF);
    busWrite(2'd2, 32'hFFF);
    @(negedge clk); rstN = 1'b0;
    waitNeg(2);
    check("R1 pinOe re-reset", 32'(oeRise), 32'h0);
    check("R1 pinOut re-reset", 32'(outRise), 32'h0);
    check("R1 irq re-reset", {31'h0, irqRise | irqFall | irqLvl}, 32'h0);
    busRead(2'd3); check("R1 capture re-reset", rdRise | rdFall, 32'h0);
    rstN = 1'b1;
    waitNeg(1);
    busRead(2'd2); check("R1 mask re-reset", rdRise, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule